// File: doc/BRIEF.md
# Two-Wire Up/Down Wiper Position Controller

This block keeps the tap position of a 32-step digital potentiometer. It is controlled over two asynchronous control lines: an active-low select and an up/down toggle line. Both lines are brought into the system clock domain through two-flop synchronizers. Edges are then detected on the synchronized levels.

When select falls, the level of the toggle line at that moment becomes the direction for the whole selected period. High means up and low means down. Each later rising edge of the toggle line moves the position by one tap in that direction. The position stops at either end and never wraps. While select is high, the position is frozen and the block reports standby.

The position is driven out both as a binary value and as a one-hot tap-select vector. A one-cycle strobe marks every real change of position. A sticky flag records any phase of the toggle line that was shorter than a parameterised minimum number of clocks. All pins are plain control and status signals, so no handshake is involved.

Top module: `wiper_pos_ctrl`

## Requirements
- R1: After reset, the position is tap 16 and tap-select bit 16 alone is set. Standby is high and the timing-error flag is low.
- R2: On the synchronized falling edge of select, the toggle line level is latched as the direction: 1 means up (toward tap 31) and 0 means down (toward tap 0).
- R3: While selected, each synchronized rising edge of the toggle line moves the position by exactly one tap in the latched direction. The new position appears three clock edges after the input changes.
- R4: Stepping up at tap 31 or down at tap 0 leaves the position unchanged, with no wrap-around.
- R5: While select is high, toggle edges have no effect on the position, the position is retained, and standby is high.
- R6: Exactly one bit of the 32-bit tap-select output is set, and it is the bit whose index equals the binary position.
- R7: A toggle rising edge seen in the same synchronized cycle as the select falling edge is not counted as a step.
- R8: The step-done strobe is high for one cycle whenever the position changes. It stays low on a saturated step attempt.
- R9: While selected, a toggle phase shorter than MIN_PHASE_CYC clocks (default 75, which is 300 ns at 250 MHz) sets the timing-error flag. The flag stays set until reset, and the step on that edge is still applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n_i | input | 1 | Active-low select, asynchronous |
| ud_i | input | 1 | Up/down toggle line, asynchronous |
| tap_sel_o | output | NUM_TAPS | One-hot tap select |
| pos_o | output | POS_W | Binary tap position |
| step_done_o | output | 1 | One-cycle strobe on a position change |
| standby_o | output | 1 | High while deselected |
| timing_err_o | output | 1 | Sticky short-phase flag |

## Verification
The toggle line is driven with several patterns:
- Legal-width runs in both directions, which separate correct stepping from stepping in the wrong direction.
- Runs long enough to push past both ends, which expose wrap-around and spurious strobes.
- Toggles while deselected, which show whether the frozen state leaks.
- A toggle edge made coincident with the select falling edge, which tells the direction capture apart from a counted step.
- A single short low phase, which must raise the error flag while still producing its step.

A reset in the middle of the sequence confirms that the position returns to midscale.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } wpc_dir_e;
endpackage

// File: rtl/wpc_sync.sv
module wpc_sync #(
  parameter int                 WIDTH   = 2,
  parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      stab_q <= RST_VAL;
    end else begin
      meta_q <= async_i;
      stab_q <= meta_q;
    end
  end

  assign sync_o = stab_q;
endmodule

// File: rtl/wpc_edge_ctrl.sv
module wpc_edge_ctrl
  import wpc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sel_n_s_i,
  input  logic     ud_s_i,
  output logic     selected_o,
  output logic     ud_edge_o,
  output logic     step_req_o,
  output wpc_dir_e dir_o
);
  logic     sel_d_q;
  logic     ud_d_q;
  wpc_dir_e dir_q;
  logic     sel_fall;
  logic     ud_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_d_q <= 1'b1;
      ud_d_q  <= 1'b0;
      dir_q   <= DIR_DOWN;
    end else begin
      sel_d_q <= sel_n_s_i;
      ud_d_q  <= ud_s_i;
      if (sel_fall) dir_q <= wpc_dir_e'(ud_s_i);
    end
  end

  assign sel_fall   = sel_d_q & ~sel_n_s_i;
  assign ud_rise    = ~ud_d_q & ud_s_i;
  assign ud_edge_o  = ud_d_q ^ ud_s_i;
  assign selected_o = ~sel_n_s_i;
  assign step_req_o = selected_o & ud_rise & ~sel_fall;
  assign dir_o      = dir_q;

  // R5
  idle_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n_s_i |-> !step_req_o);

  // R7
  fall_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_d_q && !sel_n_s_i) |-> !step_req_o);

  // R2
  dir_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_d_q && !sel_n_s_i) |=> (dir_q == wpc_dir_e'($past(ud_s_i))));
endmodule

// File: rtl/wpc_phase_mon.sv
module wpc_phase_mon #(
  parameter int MIN_PHASE_CYC = 75
) (
  input  logic clk,
  input  logic rst_n,
  input  logic selected_i,
  input  logic ud_edge_i,
  output logic err_o
);
  localparam int CNT_W = $clog2(MIN_PHASE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_PHASE_CYC);

  logic [CNT_W-1:0] len_q;
  logic             armed_q;
  logic             err_q;
  logic             short_phase;

  assign short_phase = selected_i & ud_edge_i & armed_q & (len_q < CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q   <= '0;
      armed_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (ud_edge_i)              len_q <= CNT_W'(1);
      else if (len_q != CNT_MAX)  len_q <= len_q + 1'b1;
      if (!selected_i)            armed_q <= 1'b0;
      else if (ud_edge_i)         armed_q <= 1'b1;
      if (short_phase)            err_q <= 1'b1;
    end
  end

  assign err_o = err_q;

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  // R9
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $past(selected_i && ud_edge_i));
endmodule

// File: rtl/wpc_position.sv
module wpc_position
  import wpc_pkg::*;
#(
  parameter int NUM_TAPS  = 32,
  parameter int RESET_TAP = 16,
  localparam int POS_W    = $clog2(NUM_TAPS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step_req_i,
  input  wpc_dir_e            dir_i,
  output logic [POS_W-1:0]    pos_o,
  output logic [NUM_TAPS-1:0] tap_sel_o,
  output logic                step_done_o
);
  localparam logic [POS_W-1:0] TOP_TAP = POS_W'(NUM_TAPS - 1);
  localparam logic [POS_W-1:0] MID_TAP = POS_W'(RESET_TAP);

  logic [POS_W-1:0] pos_q;
  logic             done_q;
  logic             go_up;
  logic             go_dn;

  assign go_up = step_req_i & (dir_i == DIR_UP)   & (pos_q != TOP_TAP);
  assign go_dn = step_req_i & (dir_i == DIR_DOWN) & (pos_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= MID_TAP;
      done_q <= 1'b0;
    end else begin
      done_q <= go_up | go_dn;
      if (go_up)      pos_q <= pos_q + 1'b1;
      else if (go_dn) pos_q <= pos_q - 1'b1;
    end
  end

  for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
    assign tap_sel_o[t] = (pos_q == POS_W'(t));
  end

  assign pos_o       = pos_q;
  assign step_done_o = done_q;

  // R4
  sat_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q == TOP_TAP && step_req_i && dir_i == DIR_UP) |=> (pos_q == TOP_TAP));

  // R4
  sat_bot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q == '0 && step_req_i && dir_i == DIR_DOWN) |=> (pos_q == '0));

  // R6
  one_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tap_sel_o) == 1);

  // R8
  strobe_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q != $past(pos_q)) |-> done_q);

  // R3
  one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (pos_q == $past(pos_q) + 1'b1 || pos_q == $past(pos_q) - 1'b1));
endmodule

// File: rtl/wiper_pos_ctrl.sv
module wiper_pos_ctrl
  import wpc_pkg::*;
#(
  parameter int NUM_TAPS      = 32,
  parameter int RESET_TAP     = 16,
  parameter int MIN_PHASE_CYC = 75,
  localparam int POS_W        = $clog2(NUM_TAPS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sel_n_i,
  input  logic                ud_i,
  output logic [NUM_TAPS-1:0] tap_sel_o,
  output logic [POS_W-1:0]    pos_o,
  output logic                step_done_o,
  output logic                standby_o,
  output logic                timing_err_o
);
  logic [1:0] sync_w;
  logic       selected_w;
  logic       ud_edge_w;
  logic       step_req_w;
  wpc_dir_e   dir_w;

  wpc_sync #(.WIDTH(2), .RST_VAL(2'b10)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({sel_n_i, ud_i}),
    .sync_o  (sync_w)
  );

  wpc_edge_ctrl u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_n_s_i  (sync_w[1]),
    .ud_s_i     (sync_w[0]),
    .selected_o (selected_w),
    .ud_edge_o  (ud_edge_w),
    .step_req_o (step_req_w),
    .dir_o      (dir_w)
  );

  wpc_position #(.NUM_TAPS(NUM_TAPS), .RESET_TAP(RESET_TAP)) u_pos (
    .clk         (clk),
    .rst_n       (rst_n),
    .step_req_i  (step_req_w),
    .dir_i       (dir_w),
    .pos_o       (pos_o),
    .tap_sel_o   (tap_sel_o),
    .step_done_o (step_done_o)
  );

  wpc_phase_mon #(.MIN_PHASE_CYC(MIN_PHASE_CYC)) u_mon (
    .clk        (clk),
    .rst_n      (rst_n),
    .selected_i (selected_w),
    .ud_edge_i  (ud_edge_w),
    .err_o      (timing_err_o)
  );

  assign standby_o = ~selected_w;

  // R5
  frozen_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (standby_o && $past(standby_o)) |=> $stable(pos_o));
endmodule

// File: tb/wiper_pos_ctrl_bench.sv
module wiper_pos_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_n_i = 1'b1;
  logic        ud_i = 1'b0;
  logic [31:0] tap_sel_o;
  logic [4:0]  pos_o;
  logic        step_done_o;
  logic        standby_o;
  logic        timing_err_o;

  int n_chk = 0;
  int n_fail = 0;
  int exp_q[$];
  int model_pos = 16;
  int model_up = 0;
  int model_sel = 0;

  always #2 clk = ~clk;

  wiper_pos_ctrl u_wiper_pos_ctrl (
    .clk(clk), .rst_n(rst_n), .sel_n_i(sel_n_i), .ud_i(ud_i),
    .tap_sel_o(tap_sel_o), .pos_o(pos_o), .step_done_o(step_done_o),
    .standby_o(standby_o), .timing_err_o(timing_err_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: R3/R8 each strobe must match a queued position
  always @(negedge clk) begin
    if (rst_n && step_done_o) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R8 unexpected strobe actual=%0d expected=none", pos_o);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (pos_o !== 5'(e)) begin
          n_fail++;
          $display("FAIL R3 step actual=%0d expected=%0d", pos_o, e);
        end
      end
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic toggle(int lo, int hi);
    @(negedge clk) ud_i = 1'b0;
    wait_cyc(lo);
    ud_i = 1'b1;
    if (model_sel != 0) begin
      if (model_up != 0 && model_pos < 31) begin model_pos++; exp_q.push_back(model_pos); end
      else if (model_up == 0 && model_pos > 0) begin model_pos--; exp_q.push_back(model_pos); end
    end
    wait_cyc(hi);
  endtask

  task automatic do_select();
    @(negedge clk) sel_n_i = 1'b0;
    model_sel = 1; model_up = int'(ud_i);
    wait_cyc(80);
  endtask

  task automatic do_deselect();
    @(negedge clk) sel_n_i = 1'b1;
    model_sel = 0;
    wait_cyc(6);
  endtask

  task automatic check_pos(string req);
    wait_cyc(4);
    chk(req, 32'(pos_o), 32'(model_pos));
    chk("R6", tap_sel_o, 32'(1) << model_pos);
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
    chk("R1 pos", 32'(pos_o), 32'd16);
    chk("R1 onehot", tap_sel_o, 32'h0001_0000);
    chk("R1 standby", 32'(standby_o), 32'd1);
    chk("R1 err", 32'(timing_err_o), 32'd0);

    do_select();                                  // R2: ud low -> down
    chk("R5 standby low when selected", 32'(standby_o), 32'd0);
    for (int i = 0; i < 3; i++) toggle(80, 80);
    check_pos("R3 down steps");

    do_deselect();                                // R5
    for (int i = 0; i < 2; i++) toggle(80, 80);
    check_pos("R5 frozen");
    chk("R5 standby", 32'(standby_o), 32'd1);

    do_select();                                  // R2: ud high -> up
    for (int i = 0; i < 20; i++) toggle(80, 80);
    check_pos("R4 top saturation");
    chk("R4 top", 32'(pos_o), 32'd31);

    do_deselect();
    @(negedge clk) ud_i = 1'b0;
    wait_cyc(80);
    do_select();
    for (int i = 0; i < 33; i++) toggle(80, 80);
    check_pos("R4 bottom saturation");
    chk("R4 bottom", 32'(pos_o), 32'd0);

    do_deselect();
    @(negedge clk) ud_i = 1'b0;
    wait_cyc(80);
    @(negedge clk) begin sel_n_i = 1'b0; ud_i = 1'b1; end   // R7 coincident edge
    model_sel = 1; model_up = 1;
    wait_cyc(80);
    check_pos("R7 no step on select fall");
    chk("R7 err", 32'(timing_err_o), 32'd0);
    toggle(80, 80);
    check_pos("R2 captured up");
    chk("R9 legal phases no err", 32'(timing_err_o), 32'd0);

    toggle(10, 80);                               // R9 short low phase
    check_pos("R9 step applied");
    chk("R9 err set", 32'(timing_err_o), 32'd1);
    toggle(80, 80);
    chk("R9 err sticky", 32'(timing_err_o), 32'd1);
    check_pos("R3 after err");

    @(negedge clk) rst_n = 1'b0;
    model_pos = 16;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
    chk("R1 reset restores mid", 32'(pos_o), 32'd16);
    chk("R1 reset clears err", 32'(timing_err_o), 32'd0);
    chk("R8 queue drained", 32'(exp_q.size()), 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule